// File: doc/BRIEF.md
# Capture Shutdown Handshake Sequencer

This block sits beside a video capture path that streams pixels into a line FIFO and from there into memory through an AXI write master. It holds the control and status registers software uses to start and, above all, to stop that path in a safe order. Software first turns off input processing, then watches a module-active flag fall once the frame in flight completes, then watches the FIFO write and read pointers meet. It then raises an AXI stop request and waits for the acknowledge before withdrawing the request and putting the image-processing section into soft reset.

The FIFO storage and the AXI protocol engine live outside the block. It sees the FIFO only through its pointers and the AXI master only through an outstanding-write count, and it hands back an issue-permit signal to the master. The soft-reset assertion is gated: a request to enter reset is held pending until processing is off, the active flag is low, the FIFO is empty and no AXI writes are outstanding. While the section is held in reset, the pointer readback, the active flag and the acknowledge all read as zero.

Top module: `cap_stop_seq`

## Requirements
- R1: After the block reset, the processing enable, stop request, acknowledge, active flag and input select all read 0, the soft-reset register reads 0 (section held in reset), and `axi_issue_en` is low.
- R2: Bit 0 of offset 0x200 is the processing enable; it reads back as written and drives `proc_en` from the cycle after the write.
- R3: Bit 2 of offset 0x254 is the active flag. It sets on `frame_start` while the enable is 1, stays set across a `frame_end` while the enable is 1, and clears on the first `frame_end` seen with the enable at 0. A `frame_start` while the enable is 0 does not set it.
- R4: Offset 0x168 reads the FIFO write pointer in bits 7:0 and the read pointer in bits 23:16; all other bits read 0.
- R5: Bit 0 of offset 0x174 is the AXI stop request; it reads back as written, and while it is 1 `axi_issue_en` is low.
- R6: Bit 0 of offset 0x178 is the stop acknowledge. It reads 1 from the cycle after the stop request is 1 and the outstanding count is 0. It stays 0 while writes are outstanding, it drops one cycle after the request is withdrawn, and writes to it have no effect.
- R7: Bit 0 of offset 0x00C is the active-low soft reset: writing 1 releases the section (`ip_rst_n` high) in the next cycle.
- R8: Writing 0 to offset 0x00C enters reset only once the path is quiet: enable 0, active flag 0, write pointer equal to read pointer, outstanding count 0. Until then the register reads 1 and `ip_rst_n` stays high. Writing 1 while the request is pending cancels it.
- R9: While the section is held in reset, the pointer readback is 0, the active flag reads 0 even across a `frame_start` with the enable at 1, the acknowledge reads 0, and `axi_issue_en` is low.
- R10: Bits 1:0 of offset 0x000 select the capture input; they read back as written and drive `in_sel`.
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| frame_start | input | 1 | Pixel front end: frame begins |
| frame_end | input | 1 | Pixel front end: frame finished |
| fifo_wptr | input | 8 | Line FIFO write pointer |
| fifo_rptr | input | 8 | Line FIFO luma read pointer |
| axi_outstanding | input | 6 | Number of AXI writes not yet responded |
| proc_en | output | 1 | Input processing enable |
| in_sel | output | 2 | Capture input select |
| ip_rst_n | output | 1 | Active-low reset to the image-processing section |
| axi_issue_en | output | 1 | Permit for the AXI master to issue new writes |

## Verification
The hardest state to reach is a pending reset request that must stay pending. Software has asked for reset, yet one quiet condition is still missing. The bench writes 0 to the soft-reset register while the enable is still 1 and the pointers differ. It then clears the enable and only afterwards makes the pointers equal, checking that reset lands in the cycle after the last condition is met. It repeats the setup and cancels the request with a write of 1, which must leave the section running. The forced-zero readback in reset is reached by moving the pointers and pulsing frame start with the enable set while reset is held.

// File: rtl/cap_stop_pkg.sv
// Shared constants for the capture shutdown sequencer: bus widths and the
// register offsets that software and this block agree on.
package cap_stop_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PTR_W  = 8;   // pointer fields are byte wide in the readback
    localparam int SEL_W  = 2;
    localparam int OUT_W  = 6;

    localparam logic [ADDR_W-1:0] OFS_INSEL  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SRST   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_FPTR   = 12'h168;
    localparam logic [ADDR_W-1:0] OFS_XSTOP  = 12'h174;
    localparam logic [ADDR_W-1:0] OFS_XACK   = 12'h178;
    localparam logic [ADDR_W-1:0] OFS_PEN    = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = 12'h254;

    localparam int MSTAT_ACT_BIT = 2;
endpackage

// File: rtl/cstop_regs.sv
// Writable control registers: enable, input select, stop request and the
// gated soft reset. Assumes quiet_i is valid every cycle; a request to enter
// reset waits in a pending flag until quiet_i is high.
module cstop_regs
    import cap_stop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEL_W-1:0]  wsel_i,
    input  logic              wbit0_i,
    input  logic              quiet_i,
    output logic              en_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              stop_req_o,
    output logic              srst_n_o,
    output logic              srst_pend_o
);
    // Plain read/write registers: enable, select, stop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o       <= 1'b0;
            sel_o      <= '0;
            stop_req_o <= 1'b0;
        end else if (wr_i) begin
            if (addr_i == OFS_PEN)   en_o       <= wbit0_i;
            if (addr_i == OFS_INSEL) sel_o      <= wsel_i;
            if (addr_i == OFS_XSTOP) stop_req_o <= wbit0_i;
        end
    end

    // Soft reset: release at once, enter only when the path is quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_n_o    <= 1'b0;
            srst_pend_o <= 1'b0;
        end else if (wr_i && addr_i == OFS_SRST) begin
            if (wbit0_i) begin
                srst_n_o    <= 1'b1;
                srst_pend_o <= 1'b0;
            end else if (quiet_i) begin
                srst_n_o    <= 1'b0;
                srst_pend_o <= 1'b0;
            end else begin
                srst_pend_o <= srst_n_o;
            end
        end else if (srst_pend_o && quiet_i) begin
            srst_n_o    <= 1'b0;
            srst_pend_o <= 1'b0;
        end
    end

    assert_reset_only_when_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_n_o) |-> $past(quiet_i));
endmodule

// File: rtl/cstop_activity.sv
// Module-active flag: set by a frame start while enabled, cleared by a frame
// end once the enable is low, forced low while the section is in reset.
// Assumes frame_start/frame_end are single-cycle strobes.
module cstop_activity (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_n_i,
    input  logic en_i,
    input  logic frame_start_i,
    input  logic frame_end_i,
    output logic active_o
);
    // Track whether a frame is in flight under the current enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !srst_n_i)           active_o <= 1'b0;
        else if (frame_end_i && !en_i)     active_o <= 1'b0;
        else if (frame_start_i && en_i)    active_o <= 1'b1;
    end

    assert_set_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && en_i && srst_n_i) |=> active_o);
    assert_clear_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && !en_i) |=> !active_o);
    assert_low_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_n_i |=> !active_o);
endmodule

// File: rtl/cstop_axi_stop.sv
// AXI stop handshake: withholds the issue permit while a stop is requested
// and acknowledges once no writes remain outstanding. Assumes the master
// issues nothing while the permit is low, so the count only falls.
module cstop_axi_stop
    import cap_stop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_n_i,
    input  logic             stop_req_i,
    input  logic [OUT_W-1:0] outstanding_i,
    output logic             ack_o,
    output logic             issue_en_o
);
    // Acknowledge register, cleared in soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_o <= 1'b0;
        else        ack_o <= srst_n_i && stop_req_i && (outstanding_i == '0);
    end

    // Issue permit for the AXI master.
    always_comb issue_en_o = srst_n_i && !stop_req_i;

    assert_ack_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(outstanding_i == '0) && $past(stop_req_i));
    assert_no_ack_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_n_i |=> !ack_o);
endmodule

// File: rtl/cap_stop_seq.sv
// Top of the capture shutdown sequencer: ties the control registers, the
// activity tracker and the AXI stop handshake together and decodes reads.
// Assumes the register bus is single-cycle with combinational read data.
module cap_stop_seq
    import cap_stop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic [PTR_W-1:0]  fifo_wptr,
    input  logic [PTR_W-1:0]  fifo_rptr,
    input  logic [OUT_W-1:0]  axi_outstanding,
    output logic              proc_en,
    output logic [SEL_W-1:0]  in_sel,
    output logic              ip_rst_n,
    output logic              axi_issue_en
);
    logic stop_req, srst_n, srst_pend, active, ack, quiet, fifo_empty;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:SEL_W];

    // Quiet condition that allows soft reset to be entered.
    always_comb begin
        fifo_empty = (fifo_wptr == fifo_rptr);
        quiet      = !proc_en && !active && fifo_empty && (axi_outstanding == '0);
    end

    cstop_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wsel_i     (reg_wdata[SEL_W-1:0]),
        .wbit0_i    (reg_wdata[0]),
        .quiet_i    (quiet),
        .en_o       (proc_en),
        .sel_o      (in_sel),
        .stop_req_o (stop_req),
        .srst_n_o   (srst_n),
        .srst_pend_o(srst_pend)
    );

    cstop_activity u_act (
        .clk          (clk),
        .rst_n        (rst_n),
        .srst_n_i     (srst_n),
        .en_i         (proc_en),
        .frame_start_i(frame_start),
        .frame_end_i  (frame_end),
        .active_o     (active)
    );

    cstop_axi_stop u_axi (
        .clk          (clk),
        .rst_n        (rst_n),
        .srst_n_i     (srst_n),
        .stop_req_i   (stop_req),
        .outstanding_i(axi_outstanding),
        .ack_o        (ack),
        .issue_en_o   (axi_issue_en)
    );

    assign ip_rst_n = srst_n;

    // Read decode; status that depends on the section is zero in reset.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_INSEL: reg_rdata[SEL_W-1:0] = in_sel;
            OFS_SRST:  reg_rdata[0] = srst_n || srst_pend;
            OFS_FPTR:  if (srst_n) begin
                           reg_rdata[PTR_W-1:0]   = fifo_wptr;
                           reg_rdata[16+PTR_W-1:16] = fifo_rptr;
                       end
            OFS_XSTOP: reg_rdata[0] = stop_req;
            OFS_XACK:  reg_rdata[0] = ack;
            OFS_PEN:   reg_rdata[0] = proc_en;
            OFS_MSTAT: reg_rdata[MSTAT_ACT_BIT] = active;
            default:   reg_rdata = '0;
        endcase
    end

    assert_no_issue_while_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> !axi_issue_en);
endmodule

// File: tb/cap_stop_seq_tb_top.sv
module cap_stop_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0, frame_end = 1'b0;
    logic [7:0]  fifo_wptr = '0, fifo_rptr = '0;
    logic [5:0]  axi_outstanding = '0;
    logic        proc_en, ip_rst_n, axi_issue_en;
    logic [1:0]  in_sel;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cap_stop_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
        .frame_end(frame_end), .fifo_wptr(fifo_wptr), .fifo_rptr(fifo_rptr),
        .axi_outstanding(axi_outstanding), .proc_en(proc_en), .in_sel(in_sel),
        .ip_rst_n(ip_rst_n), .axi_issue_en(axi_issue_en)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FIL%s %s: got %h expected %h", "", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(12'h200, d); chk("R1 enable", d, 0);
        rd(12'h00C, d); chk("R1 soft reset", d, 0);
        rd(12'h174, d); chk("R1 stop req", d, 0);
        rd(12'h178, d); chk("R1 ack", d, 0);
        rd(12'h254, d); chk("R1 active", d, 0);
        rd(12'h000, d); chk("R1 select", d, 0);
        chk("R1 issue_en", axi_issue_en, 0);
    endtask

    task automatic t_release();
        logic [31:0] d;
        wr(12'h00C, 1);
        rd(12'h00C, d); chk("R7 readback", d, 1);
        chk("R7 ip_rst_n", ip_rst_n, 1);
        chk("R7 issue_en", axi_issue_en, 1);
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(12'h000, 32'hFFFF_FFF2);
        rd(12'h000, d); chk("R10 readback", d, 2);
        chk("R10 in_sel", in_sel, 2);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(12'h200, 1);
        rd(12'h200, d); chk("R2 readback", d, 1);
        chk("R2 proc_en", proc_en, 1);
    endtask

    task automatic t_pointers();
        logic [31:0] d;
        fifo_wptr = 8'h35; fifo_rptr = 8'h12;
        rd(12'h168, d); chk("R4 pointers", d, 32'h0012_0035);
    endtask

    task automatic t_active();
        logic [31:0] d;
        pulse_start();
        rd(12'h254, d); chk("R3 set on start", d, 4);
        pulse_end();
        rd(12'h254, d); chk("R3 held over end while enabled", d, 4);
        wr(12'h200, 0);
        rd(12'h254, d); chk("R3 held after disable", d, 4);
        pulse_end();
        rd(12'h254, d); chk("R3 cleared on end", d, 0);
        pulse_start();
        rd(12'h254, d); chk("R3 no set while disabled", d, 0);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        axi_outstanding = 6'd3;
        wr(12'h174, 1);
        rd(12'h174, d); chk("R5 readback", d, 1);
        chk("R5 issue_en low", axi_issue_en, 0);
        @(negedge clk);
        rd(12'h178, d); chk("R6 no ack while outstanding", d, 0);
        axi_outstanding = 6'd0;
        @(negedge clk);
        rd(12'h178, d); chk("R6 ack after drain", d, 1);
        wr(12'h178, 0);
        rd(12'h178, d); chk("R6 write to ack ignored", d, 1);
        wr(12'h174, 0);
        @(negedge clk);
        rd(12'h178, d); chk("R6 ack withdrawn", d, 0);
    endtask

    task automatic t_gated_reset();
        logic [31:0] d;
        wr(12'h200, 1);
        wr(12'h00C, 0);
        rd(12'h00C, d); chk("R8 pending reads 1", d, 1);
        chk("R8 not yet in reset", ip_rst_n, 1);
        wr(12'h200, 0);
        @(negedge clk);
        chk("R8 waits for fifo empty", ip_rst_n, 1);
        fifo_rptr = 8'h35;
        @(negedge clk);
        chk("R8 reset applied when quiet", ip_rst_n, 0);
        rd(12'h00C, d); chk("R8 reads 0 in reset", d, 0);
    endtask

    task automatic t_in_reset();
        logic [31:0] d;
        fifo_wptr = 8'h44; fifo_rptr = 8'h11;
        rd(12'h168, d); chk("R9 pointers zero", d, 0);
        wr(12'h200, 1);
        pulse_start();
        rd(12'h254, d); chk("R9 active zero", d, 0);
        wr(12'h174, 1);
        @(negedge clk);
        rd(12'h178, d); chk("R9 ack zero", d, 0);
        chk("R9 issue_en low", axi_issue_en, 0);
    endtask

    task automatic t_cancel();
        logic [31:0] d;
        wr(12'h00C, 1);
        wr(12'h00C, 0);
        wr(12'h00C, 1);
        wr(12'h200, 0);
        wr(12'h174, 0);
        fifo_rptr = 8'h44;
        repeat (3) @(negedge clk);
        chk("R8 cancelled request stays out of reset", ip_rst_n, 1);
        rd(12'h00C, d); chk("R8 cancelled readback", d, 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'h004, d); chk("R11 offset 0x004", d, 0);
        rd(12'h17C, d); chk("R11 offset 0x17C", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_release();
        t_select();
        t_enable();
        t_pointers();
        t_active();
        t_stop();
        t_gated_reset();
        t_in_reset();
        t_cancel();
        t_unmapped();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule